// File: doc/BRIEF.md
# In-Place Insertion Sorter

This block keeps a small array of words in its own register file and rearranges it into ascending unsigned order by insertion sort. Software-side logic, or a neighbouring block, fills the array through a write port while the sorter is idle. It then pulses a launch input and waits for a one-cycle completion pulse. After that pulse it reads the ordered words back through an asynchronous read port.

Control is split between two cooperating state machines. The outer machine steps a position counter from 1 up to the last slot. For each position it captures the word there as the key and hands the search off to the inner machine. When the inner machine reports that it has finished, the outer machine writes the key into the gap that was left.

The inner machine walks downward from the slot just below the key. While the key is strictly smaller than the word it is looking at, it copies that word one slot up. It stops at the first word that is not larger than the key, or after it has moved the word in slot 0. Because the number of inner passes depends on the data, each outer step takes as many cycles as it needs, with no fixed initiation interval.

Top module: `isort_top`

## Requirements
- R1: After synchronous reset, busy and done are both 0 and every slot reads back as 0.
- R2: While busy is 0, a cycle with load_en=1 writes load_data into slot load_addr at the clock edge. The read port combinationally returns the current contents of slot rd_addr at all times, including mid-sort.
- R3: A cycle with start=1 while busy is 0 begins a sort. busy is 1 from the next cycle until the final write of the sort.
- R4: When a sort completes, slots 0 to N-1 hold the original words in non-decreasing unsigned order.
- R5: The inner loop stops at the first word that is less than or equal to the key, so equal words are never moved past each other. An array of identical words therefore takes 3 cycles per outer step.
- R6: Outer step j occupies 2 + s + e cycles of busy. Here s is the number of words shifted up, and e is 1 if the search ended on a comparison and 0 if it ran past slot 0. Each shift becomes visible on the read port one cycle after the previous one.
- R7: done is a single-cycle pulse in the cycle right after the last busy cycle, and busy is 0 during it.
- R8: load_en and start are ignored while busy is 1. The array contents and the sort progress are unaffected.
- R9: An already ascending array finishes in 3*(N-1) busy cycles.
- R10: A strictly descending array finishes in 2*(N-1) + N*(N-1)/2 busy cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one word into the array (honoured only when idle) |
| load_addr | input | $clog2(N) | Slot written by the load port |
| load_data | input | DW | Word written by the load port |
| start | input | 1 | Launch a sort (honoured only when idle) |
| busy | output | 1 | Sort in progress |
| done | output | 1 | One-cycle pulse after the sort finishes |
| rd_addr | input | $clog2(N) | Slot observed on the read port |
| rd_data | output | DW | Asynchronous contents of slot rd_addr |

## Verification
The hardest case to reach from the ports is a search that runs past slot 0 next to one that stops on a compare. The cycle counts of these two differ by exactly one, so a wrong exit rule changes only the timing, not the final order. The stimulus therefore combines four kinds of array: mixed data with duplicates and a zero, ascending data, descending data and all-equal data. A behavioural model predicts every intermediate shift, and the read address is swept on every cycle during the sort, so each partial state of the array is compared. One run also keeps load and start asserted through the whole sort, to show that neither input has any effect while the sorter is busy.

// File: rtl/isort_pkg.sv
package isort_pkg;

    typedef enum logic [1:0] {
        O_IDLE  = 2'd0,
        O_FETCH = 2'd1,
        O_WAIT  = 2'd2,
        O_PLACE = 2'd3
    } outer_state_e;

    typedef enum logic {
        I_IDLE = 1'b0,
        I_RUN  = 1'b1
    } inner_state_e;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_LOAD  = 2'd1,
        WR_SHIFT = 2'd2,
        WR_PLACE = 2'd3
    } wr_src_e;

    function automatic wr_src_e pick_writer(input logic sh, input logic pl, input logic ld);
        if (sh)      return WR_SHIFT;
        else if (pl) return WR_PLACE;
        else if (ld) return WR_LOAD;
        else         return WR_NONE;
    endfunction

endpackage

// File: rtl/isort_regfile.sv
module isort_regfile #(
    parameter int N  = 8,
    parameter int DW = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b,
    input  logic [AW-1:0] raddr_c,
    output logic [DW-1:0] rdata_c
);
    logic [DW-1:0] mem [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we && waddr == AW'(g))
                mem[g] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
    assign rdata_c = mem[raddr_c];
endmodule

// File: rtl/isort_inner_fsm.sv
module isort_inner_fsm
    import isort_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] key,
    output logic [AW-1:0] probe_addr,
    input  logic [DW-1:0] probe_val,
    output logic          sh_we,
    output logic [AW-1:0] sh_addr,
    output logic [DW-1:0] sh_data,
    output logic          fin,
    output logic [AW-1:0] gap_addr
);
    inner_state_e     st;
    logic signed [AW:0] idx;
    logic             larger;
    logic             running;

    assign running    = (st == I_RUN);
    assign probe_addr = idx[AW-1:0];
    assign larger     = key < probe_val;
    assign sh_we      = running && larger;
    assign sh_addr    = AW'(idx + 1);
    assign sh_data    = probe_val;
    assign fin        = running && (!larger || idx == '0);
    assign gap_addr   = AW'(idx + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= I_IDLE;
            idx <= '0;
        end else begin
            case (st)
                I_IDLE: if (go) begin
                    st  <= I_RUN;
                    idx <= $signed({1'b0, base});
                end
                I_RUN: begin
                    if (larger) idx <= idx - 1;
                    if (fin)    st  <= I_IDLE;
                end
                default: st <= I_IDLE;
            endcase
        end
    end

    // R6
    inner_go_idle_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> st == I_IDLE);

    // R6
    inner_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> idx >= 0);
endmodule

// File: rtl/isort_outer_fsm.sv
module isort_outer_fsm
    import isort_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          inner_fin,
    input  logic [AW-1:0] gap_addr,
    output logic [AW-1:0] fetch_addr,
    input  logic [DW-1:0] fetch_val,
    output logic          go,
    output logic [AW-1:0] base,
    output logic [DW-1:0] key,
    output logic          pl_we,
    output logic [AW-1:0] pl_addr,
    output logic [DW-1:0] pl_data,
    output logic          busy,
    output logic          done
);
    localparam logic [AW:0] LAST = (AW+1)'(N - 1);

    outer_state_e st;
    logic [AW:0]  j;

    assign busy       = (st != O_IDLE);
    assign fetch_addr = j[AW-1:0];
    assign base       = AW'(j - 1);
    assign go         = (st == O_FETCH);
    assign pl_we      = (st == O_PLACE);
    assign pl_addr    = gap_addr;
    assign pl_data    = key;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= O_IDLE;
            j    <= '0;
            key  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                O_IDLE: if (start) begin
                    st <= O_FETCH;
                    j  <= (AW+1)'(1);
                end
                O_FETCH: begin
                    key <= fetch_val;
                    st  <= O_WAIT;
                end
                O_WAIT: if (inner_fin) st <= O_PLACE;
                O_PLACE: begin
                    if (j == LAST) begin
                        st   <= O_IDLE;
                        done <= 1'b1;
                    end else begin
                        j  <= j + 1;
                        st <= O_FETCH;
                    end
                end
                default: st <= O_IDLE;
            endcase
        end
    end

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    place_after_fin_chk: assert property (@(posedge clk) disable iff (rst)
        (st == O_PLACE) |-> $past(inner_fin));
endmodule

// File: rtl/isort_top.sv
module isort_top
    import isort_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic          go, inner_fin, sh_we, pl_we, ld_we, we;
    logic [AW-1:0] base, gap_addr, fetch_addr, probe_addr, sh_addr, pl_addr, waddr;
    logic [DW-1:0] key, fetch_val, probe_val, sh_data, pl_data, wdata;
    wr_src_e       src;

    assign ld_we = load_en && !busy;
    assign src   = pick_writer(sh_we, pl_we, ld_we);

    always_comb begin
        we    = 1'b1;
        waddr = load_addr;
        wdata = load_data;
        case (src)
            WR_SHIFT: begin waddr = sh_addr; wdata = sh_data; end
            WR_PLACE: begin waddr = pl_addr; wdata = pl_data; end
            WR_LOAD:  begin waddr = load_addr; wdata = load_data; end
            default:  we = 1'b0;
        endcase
    end

    isort_regfile #(.N(N), .DW(DW), .AW(AW)) u_rf (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr_a(fetch_addr), .rdata_a(fetch_val),
        .raddr_b(probe_addr), .rdata_b(probe_val),
        .raddr_c(rd_addr),    .rdata_c(rd_data)
    );

    isort_outer_fsm #(.N(N), .DW(DW), .AW(AW)) u_outer (
        .clk(clk), .rst(rst), .start(start), .inner_fin(inner_fin),
        .gap_addr(gap_addr), .fetch_addr(fetch_addr), .fetch_val(fetch_val),
        .go(go), .base(base), .key(key), .pl_we(pl_we), .pl_addr(pl_addr),
        .pl_data(pl_data), .busy(busy), .done(done)
    );

    isort_inner_fsm #(.N(N), .DW(DW), .AW(AW)) u_inner (
        .clk(clk), .rst(rst), .go(go), .base(base), .key(key),
        .probe_addr(probe_addr), .probe_val(probe_val), .sh_we(sh_we),
        .sh_addr(sh_addr), .sh_data(sh_data), .fin(inner_fin), .gap_addr(gap_addr)
    );

    // R8
    one_writer_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sh_we, pl_we, ld_we}));

    // R8
    load_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && load_en) |=> busy || done);
endmodule

// File: tb/isort_top_tb.sv
module isort_top_tb;
    localparam int N  = 8;
    localparam int DW = 8;
    localparam int AW = $clog2(N);

    logic          clk = 0;
    logic          rst = 1;
    logic          load_en = 0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic          start = 0;
    logic          busy, done;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    bit scan = 1;

    int m [N];
    bit m_busy = 0;
    bit m_done = 0;

    always #5 clk = ~clk;

    isort_top #(.N(N), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .start(start), .busy(busy), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_sort();
        for (int j = 1; j < N; j++) begin
            int key, i;
            @(posedge clk);
            key = m[j];
            i = j - 1;
            forever begin
                @(posedge clk);
                if (key < m[i]) begin
                    m[i+1] = m[i];
                    i = i - 1;
                    if (i < 0) break;
                end else break;
            end
            @(posedge clk);
            m[i+1] = key;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (rst) begin
                for (int k = 0; k < N; k++) m[k] = 0;
                m_busy = 0;
                m_done = 0;
            end else begin
                m_done = 0;
                if (load_en) m[load_addr] = int'(load_data);
                if (start) begin
                    m_busy = 1;
                    model_sort();
                    m_busy = 0;
                    m_done = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R3 busy", int'(busy), int'(m_busy));
            check("R7 done", int'(done), int'(m_done));
            check(m_busy ? "R6 read mid-sort" : "R2 read", int'(rd_data), m[rd_addr]);
            if (scan) rd_addr = rd_addr + 1'b1;
        end
    end

    function automatic int exp_latency(input int v [N]);
        int c [N];
        int sum;
        c = v;
        sum = 0;
        for (int j = 1; j < N; j++) begin
            int key, i, r;
            key = c[j];
            i = j - 1;
            r = 0;
            while (i >= 0 && key < c[i]) begin
                c[i+1] = c[i];
                i--;
                r++;
            end
            sum += 2 + r + ((i >= 0) ? 1 : 0);
            c[i+1] = key;
        end
        return sum;
    endfunction

    task automatic load_all(input int v [N]);
        for (int k = 0; k < N; k++) begin
            @(negedge clk); #2;
            load_en = 1; load_addr = AW'(k); load_data = DW'(v[k]);
        end
        @(negedge clk); #2;
        load_en = 0;
    endtask

    task automatic do_sort(input bit disturb, output int cyc);
        int guard;
        @(negedge clk); #2;
        start = 1;
        @(negedge clk);
        cyc = busy ? 1 : 0;
        #2;
        start = disturb; load_en = disturb; load_addr = '0; load_data = '1;
        guard = 0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            cyc++;
            guard++;
            if (guard > 1000) break;
            #2;
            start = disturb; load_en = disturb; load_data = load_data - 1'b1;
        end
        check("R7 done after busy", int'(done), 1);
        #2;
        start = 0; load_en = 0;
    endtask

    task automatic check_sorted(input string req, input int v [N]);
        int s [N];
        s = v;
        s.sort();
        scan = 0;
        for (int k = 0; k < N; k++) begin
            @(negedge clk); #2;
            rd_addr = AW'(k);
            @(negedge clk);
            check(req, int'(rd_data), s[k]);
        end
        scan = 1;
    endtask

    initial begin
        int cyc;
        int va [N] = '{37, 5, 200, 5, 99, 0, 150, 37};
        int vs [N] = '{1, 2, 3, 4, 5, 6, 7, 8};
        int vr [N] = '{80, 70, 60, 50, 40, 30, 20, 10};
        int ve [N] = '{42, 42, 42, 42, 42, 42, 42, 42};
        int vb [N] = '{9, 3, 7, 1, 8, 2, 6, 4};

        repeat (3) @(negedge clk);
        #2 rst = 0;
        @(negedge clk);
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        scan = 0;
        for (int k = 0; k < N; k++) begin
            #2 rd_addr = AW'(k);
            @(negedge clk);
            check("R1 slot reset", int'(rd_data), 0);
        end
        scan = 1;

        load_all(va);
        do_sort(0, cyc);
        check("R6 mixed latency", cyc, exp_latency(va));
        check_sorted("R4 mixed order", va);

        load_all(vs);
        do_sort(0, cyc);
        check("R9 ascending latency", cyc, 3 * (N - 1));
        check_sorted("R4 ascending order", vs);

        load_all(vr);
        do_sort(0, cyc);
        check("R10 descending latency", cyc, 2 * (N - 1) + N * (N - 1) / 2);
        check_sorted("R4 descending order", vr);

        load_all(ve);
        do_sort(0, cyc);
        check("R5 equal latency", cyc, 3 * (N - 1));
        check_sorted("R5 equal order", ve);

        load_all(vb);
        do_sort(1, cyc);
        check("R8 disturbed latency", cyc, exp_latency(vb));
        check_sorted("R8 disturbed order", vb);

        repeat (3) @(negedge clk);
        check("R7 no stray done", int'(done), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule